// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block guesses whether a conditional branch will be taken. Each table row belongs to a branch address and holds one small saturating counter for every possible pattern of recent global outcomes. The row comes from low-order bits of the branch PC. The pattern comes from a shift register that records what the last few executed branches did, whichever branches they were. Rows carry no tag, so two branches whose PCs share the index bits share a row.

A fetch stage presents a PC on the lookup port and gets back a taken/not-taken guess together with the current history value. The pipeline keeps that history value and returns it with the resolved outcome on the update port. The update trains the counter picked by the PC and the returned history, then shifts the outcome into the global history.

Parameters set the history length `HIST_LEN` (0 to 4), the counter width `CTR_W` (1 or 2) and the row count `ROWS` (a power of two). A history length of 0 gives a plain per-address predictor. A counter width of 1 gives a counter that stores the last outcome it saw.

Top module: `corr_bpred`

## Requirements
- R1: When synchronous active-low reset is applied, the global history becomes 0 and every counter becomes weakly not-taken (value 1 for 2-bit counters, 0 for 1-bit counters). After reset, every lookup therefore predicts not-taken.
- R2: Lookup is combinational and reads the counter at row `lk_pc[PC_LSB +: log2(ROWS)]` (PC_LSB defaults to 2), with the counter selected inside the row by the current history value. `lk_taken` is the counter's most significant bit, and `lk_hist` always shows the current history.
- R3: With 2-bit counters, a taken update adds one up to a ceiling of 3, and a not-taken update subtracts one down to a floor of 0. Values 2 and 3 predict taken; values 0 and 1 predict not-taken.
- R4: An update trains only the counter selected by `up_pc` and the snapshot `up_hist`, not the current history. The other counters in the same row keep their values.
- R5: Each update shifts `up_taken` into bit 0 of the global history, which moves the older bits up by one. The oldest bit is dropped.
- R6: While `up_valid` is low, the history and all counters hold their values, whatever is driven on `up_pc`, `up_taken` and `up_hist`.
- R7: PC bits above the index field and below `PC_LSB` play no part, so addresses that differ only in those bits alias to the same row. Addresses that differ in the index field use separate rows.
- R8: If a lookup and an update select the same counter in one cycle, the lookup returns the value from before the update. The trained value can be seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | Fetch PC to predict |
| lk_taken | output | 1 | Prediction, 1 = taken |
| lk_hist | output | max(HIST_LEN,1) | Current global history, to be kept as the snapshot |
| up_valid | input | 1 | A branch has resolved this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_hist | input | max(HIST_LEN,1) | History snapshot taken at prediction time |

## Verification
Lookup and update can hit the same counter in the same cycle. The bench provokes this by first driving the history to a known value. It then presents a taken update and a lookup that select that same counter, both in one cycle. The prediction is sampled before the clock edge and must still show the untrained weak not-taken value. After the history is steered back to the same pattern, a second lookup must show the trained taken value, which proves the write happened one cycle later and was not lost.

// File: rtl/corr_bpred_pkg.sv
// Package: shared helpers for the correlating predictor.
// Assumes counter widths of at most 8 bits.
package corr_bpred_pkg;

    // Saturating step of an unsigned counter whose ceiling is maxv.
    function automatic logic [7:0] ctr_step(input logic [7:0] cur,
                                            input logic [7:0] maxv,
                                            input logic       up);
        logic [7:0] res;
        if (up) res = (cur == maxv) ? cur : cur + 8'd1;
        else    res = (cur == 8'd0) ? cur : cur - 8'd1;
        return res;
    endfunction

    // Weakly not-taken value for a counter of width w: 2^(w-1)-1.
    function automatic logic [7:0] ctr_weak_nt(input int w);
        return 8'((1 << (w - 1)) - 1);
    endfunction

endpackage

// File: rtl/corr_bpred_ghr.sv
// Module: global outcome history register.
// On every update the resolved outcome enters bit 0 and the oldest bit falls out.
// Assumes HW = max(HIST_LEN,1). With HIST_LEN = 0 the output is held at zero.
module corr_bpred_ghr #(
    parameter int HIST_LEN = 2,
    localparam int HW = (HIST_LEN > 0) ? HIST_LEN : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          outcome,
    output logic [HW-1:0] hist
);
    generate
        if (HIST_LEN > 0) begin : g_hist
            logic [HW-1:0] hist_q;
            // Purpose: clear on reset, shift in the outcome on each update.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist_q <= '0;
                else if (shift_en) hist_q <= HW'({hist_q, outcome});
            end
            assign hist = hist_q;
        end else begin : g_nohist
            logic unused_hist_in;
            assign unused_hist_in = shift_en ^ outcome ^ clk ^ rst_n;
            assign hist = '0;
        end
    endgenerate
endmodule

// File: rtl/corr_bpred_ctab.sv
// Module: counter array, ROWS rows of 2^HIST_LEN saturating counters each.
// It has one combinational read port and one registered read-modify-write port.
// A read in the same cycle as a write to the same entry sees the old value.
module corr_bpred_ctab #(
    parameter int ROWS     = 64,
    parameter int HIST_LEN = 2,
    parameter int CTR_W    = 2,
    localparam int IDX_W   = $clog2(ROWS),
    localparam int ENT_W   = IDX_W + HIST_LEN,
    localparam int ENTRIES = ROWS << HIST_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ENT_W-1:0] rd_idx,
    output logic             rd_msb,
    input  logic             wr_en,
    input  logic [ENT_W-1:0] wr_idx,
    input  logic             wr_up
);
    import corr_bpred_pkg::*;

    localparam logic [7:0]       MAXV = 8'((1 << CTR_W) - 1);
    localparam logic [CTR_W-1:0] INIT = CTR_W'(ctr_weak_nt(CTR_W));

    logic [CTR_W-1:0] ctr_q [ENTRIES];
    logic [CTR_W-1:0] wr_next;

    // Purpose: saturating next value of the entry being trained.
    always_comb wr_next = CTR_W'(ctr_step(8'(ctr_q[wr_idx]), MAXV, wr_up));

    // Purpose: load weak not-taken on reset, otherwise train one entry per update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= INIT;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= wr_next;
        end
    end

    // Purpose: the prediction is the counter's top bit.
    always_comb rd_msb = ctr_q[rd_idx][CTR_W-1];
endmodule

// File: rtl/corr_bpred.sv
// Module: (HIST_LEN, CTR_W) correlating branch predictor top.
// Low PC bits pick a row, and global history picks a counter inside that row.
// Assumes ROWS is a power of two, HIST_LEN is 0..4 and CTR_W is 1 or 2.
// The caller returns the lookup-time history with each update.
module corr_bpred #(
    parameter int PC_W     = 32,
    parameter int PC_LSB   = 2,
    parameter int ROWS     = 64,
    parameter int HIST_LEN = 2,
    parameter int CTR_W    = 2,
    localparam int HW      = (HIST_LEN > 0) ? HIST_LEN : 1,
    localparam int IDX_W   = $clog2(ROWS),
    localparam int ENT_W   = IDX_W + HIST_LEN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic [HW-1:0]   lk_hist,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic [HW-1:0]   up_hist
);
    logic [ENT_W-1:0] rd_idx, wr_idx;
    logic [HW-1:0]    cur_hist;
    logic             unused_pc_bits;

    // Combines a row number and a history pattern into a flat entry index.
    function automatic logic [ENT_W-1:0] ent_index(input logic [PC_W-1:0] pc,
                                                   input logic [HW-1:0]   h);
        logic [ENT_W-1:0] idx;
        idx = ENT_W'(pc[PC_LSB +: IDX_W]) << HIST_LEN;
        if (HIST_LEN > 0) idx = idx | ENT_W'(h);
        return idx;
    endfunction

    // Purpose: form the read index from the fetch PC and the live history.
    always_comb rd_idx = ent_index(lk_pc, cur_hist);

    // Purpose: form the write index from the resolved PC and its snapshot.
    always_comb wr_idx = ent_index(up_pc, up_hist);

    assign unused_pc_bits = ^{lk_pc, up_pc, up_hist};
    assign lk_hist        = cur_hist;

    corr_bpred_ghr #(.HIST_LEN(HIST_LEN)) u_ghr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .outcome  (up_taken),
        .hist     (cur_hist)
    );

    corr_bpred_ctab #(.ROWS(ROWS), .HIST_LEN(HIST_LEN), .CTR_W(CTR_W)) u_ctab (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (rd_idx),
        .rd_msb (lk_taken),
        .wr_en  (up_valid),
        .wr_idx (wr_idx),
        .wr_up  (up_taken)
    );
endmodule

// File: rtl/corr_bpred_chk.sv
// Module: property checker for corr_bpred, attached with bind.
// It watches only the top-level ports.
module corr_bpred_chk #(
    parameter int PC_W     = 32,
    parameter int HIST_LEN = 2,
    localparam int HW      = (HIST_LEN > 0) ? HIST_LEN : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_taken,
    input logic [HW-1:0]   lk_hist,
    input logic            up_valid,
    input logic            up_taken
);
    // R1: the first cycle out of reset shows an empty history.
    a_r1_hist_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> lk_hist == '0);

    // R5: an update shifts its outcome into bit 0.
    a_r5_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> lk_hist == HW'({$past(lk_hist), $past(up_taken)}));

    // R6: no update means the history holds.
    a_r6_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(lk_hist));

    // R6: no update and an unchanged PC means the prediction holds.
    a_r6_pred_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> (!$stable(lk_pc) || $stable(lk_taken)));
endmodule

bind corr_bpred corr_bpred_chk #(.PC_W(PC_W), .HIST_LEN(HIST_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_pc    (lk_pc),
    .lk_taken (lk_taken),
    .lk_hist  (lk_hist),
    .up_valid (up_valid),
    .up_taken (up_taken)
);

// File: tb/corr_bpred_test.sv
// Directed bench for corr_bpred with the default parameters (HIST_LEN=2, CTR_W=2, ROWS=64).
module corr_bpred_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_taken;
    logic [1:0]  lk_hist;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [1:0]  up_hist = '0;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [31:0] PC_A = 32'h0000_1004; // row 1
    localparam logic [31:0] PC_B = 32'h0000_1008; // row 2
    localparam logic [31:0] PC_C = 32'h0000_100C; // row 3
    localparam logic [31:0] PC_D = 32'h0000_1014; // row 5
    localparam logic [31:0] PC_S = 32'h0000_10FC; // row 63, scratch

    always #10 clk = ~clk;

    corr_bpred uut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_hist(lk_hist), .up_valid(up_valid), .up_pc(up_pc),
        .up_taken(up_taken), .up_hist(up_hist)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One update in one cycle, then the update is withdrawn.
    task automatic upd(input logic [31:0] pc, input logic t, input logic [1:0] h);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_taken = t; up_hist = h;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    // Steer the history to h with updates to the scratch row.
    task automatic set_hist(input logic [1:0] h);
        upd(PC_S, h[1], 2'b00);
        upd(PC_S, h[0], 2'b00);
    endtask

    task automatic look(input string req, input logic [31:0] pc, input logic exp);
        @(negedge clk);
        lk_pc = pc;
        #1 check(req, 32'(lk_taken), 32'(exp));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 hist", 32'(lk_hist), 0);
        look("R1 pred A", PC_A, 1'b0);
        look("R1 pred D", PC_D, 1'b0);
    endtask

    // Walk row A, history 00, through the whole counter range.
    task automatic t_counter;
        upd(PC_A, 1'b1, 2'b00);                 // 1 -> 2
        set_hist(2'b00); look("R3 weak taken", PC_A, 1'b1);
        repeat (3) upd(PC_A, 1'b1, 2'b00);      // saturates at 3
        upd(PC_A, 1'b0, 2'b00);                 // 3 -> 2
        set_hist(2'b00); look("R3 top saturation", PC_A, 1'b1);
        upd(PC_A, 1'b0, 2'b00);                 // 2 -> 1
        set_hist(2'b00); look("R3 weak not-taken", PC_A, 1'b0);
        repeat (3) upd(PC_A, 1'b0, 2'b00);      // saturates at 0
        upd(PC_A, 1'b1, 2'b00);                 // 0 -> 1
        set_hist(2'b00); look("R3 bottom saturation", PC_A, 1'b0);
    endtask

    // Train row B with snapshot 01 while the live history is 11.
    task automatic t_snapshot;
        set_hist(2'b11);
        @(negedge clk);
        up_valid = 1'b1; up_pc = PC_B; up_taken = 1'b1; up_hist = 2'b01;
        @(negedge clk);
        up_valid = 1'b0;
        set_hist(2'b01); look("R4 snapshot counter", PC_B, 1'b1);
        check("R2 hist out", 32'(lk_hist), 32'h1);
        set_hist(2'b11); look("R4 live-history counter", PC_B, 1'b0);
        set_hist(2'b10); look("R4 sibling counter", PC_B, 1'b0);
    endtask

    task automatic t_history;
        set_hist(2'b10);
        check("R5 steer", 32'(lk_hist), 32'h2);
        upd(PC_S, 1'b1, 2'b00);
        check("R5 shift taken", 32'(lk_hist), 32'h1);
        upd(PC_S, 1'b0, 2'b00);
        check("R5 shift not-taken", 32'(lk_hist), 32'h2);
    endtask

    // up_* wiggles with up_valid low: nothing may change.
    task automatic t_idle;
        set_hist(2'b00);
        @(negedge clk);
        up_valid = 1'b0; up_pc = PC_C; up_taken = 1'b1; up_hist = 2'b00;
        repeat (3) @(negedge clk);
        check("R6 hist hold", 32'(lk_hist), 0);
        look("R6 counter hold", PC_C, 1'b0);
    endtask

    task automatic t_alias;
        upd(PC_C, 1'b1, 2'b01);
        set_hist(2'b01);
        look("R7 index row", PC_C, 1'b1);
        look("R7 upper bits alias", PC_C + 32'h100, 1'b1);
        look("R7 low bits ignored", PC_C + 32'h3, 1'b1);
        look("R7 neighbour row", PC_C + 32'h4, 1'b0);
    endtask

    task automatic t_collision;
        set_hist(2'b10);
        @(negedge clk);
        lk_pc = PC_D;
        up_valid = 1'b1; up_pc = PC_D; up_taken = 1'b1; up_hist = 2'b10;
        #1 check("R8 pre-update value", 32'(lk_taken), 0);
        @(negedge clk);
        up_valid = 1'b0;
        set_hist(2'b10); look("R8 trained next cycle", PC_D, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_counter();
        t_snapshot();
        t_history();
        t_idle();
        t_alias();
        t_collision();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule